// File: doc/BRIEF.md
# Waited-Transfer Protocol Monitor for a Single-Manager AHB5 Link

This block passively observes one manager-to-subordinate AHB5 connection. It flags the protocol mistakes that can happen while a transfer is held in wait states, meaning the cycles in which the ready input is low. It drives nothing onto the bus. It can sit beside any link in a design or in an emulation build, and it raises a sticky flag for each broken rule.

Each rising edge compares the present bus values with a registered copy of the previous cycle. When that previous cycle was a wait, three checks run:

- The transfer type may move only along the paths the protocol allows. When it holds, the address-phase controls must hold too.
- A stalled write keeps its data unchanged.
- An error response has the two-cycle form.

Read data and the extended-OK response are never examined. A change of the response bit during a wait is not treated as an error in itself.

Top module: `ahb_wait_monitor`

## Requirements
- R1: After reset all three flags and the violation pulse read 0. The first rising edge after reset release performs no check, whatever the bus shows.
- R2: During a write data phase (a NONSEQ 2'b10 or SEQ 2'b11 transfer accepted with write_en high), the write data must equal its previous-cycle value on every edge whose previous cycle had ready_in low. A mismatch sets flag_wdata_o.
- R3: Write data may change freely during the data phase of a read, and between the accepting cycle and the first data cycle.
- R4: After a waited cycle, the transfer type may step from IDLE (2'b00) to NONSEQ (2'b10), with new address-phase controls, without a violation.
- R5: After a waited BUSY (2'b01) cycle of any burst other than the undefined-length one, the only legal change of type is to SEQ (2'b11). Any other change sets flag_ctrl_o, unless R7 applies.
- R6: After a waited BUSY cycle of the undefined-length incrementing burst (burst_kind 3'b001), the type may change to any value without a violation.
- R7: After a waited cycle in which resp_err was high, a change of type to IDLE is legal, together with any change of the controls.
- R8: After a waited cycle, if the transfer type is unchanged then addr, write_en, xfer_size, burst_kind and prot_attr must all be unchanged. A change of type not allowed by R4 to R7 also sets flag_ctrl_o.
- R9: resp_err changing while ready_in is low does not by itself raise any flag.
- R10: An error response is exactly one cycle of resp_err=1, ready_in=0 followed by one cycle of resp_err=1, ready_in=1. Any other pattern involving either half sets flag_resp_o.
- R11: viol_o is high for exactly the one cycle after an edge on which any rule failed. Each flag, once set, stays set until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| trans_type | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| addr | input | ADDR_W | Address of the address phase |
| write_en | input | 1 | Direction, 1 for write |
| xfer_size | input | 3 | Transfer size code |
| burst_kind | input | 3 | Burst type code, 001 is undefined-length incrementing |
| prot_attr | input | 4 | Protection attributes |
| wr_data | input | DATA_W | Write data bus |
| ready_in | input | 1 | Transfer-complete signal seen by the subordinate |
| resp_err | input | 1 | Response bit, 1 signals ERROR |
| flag_ctrl_o | output | 1 | Sticky: illegal type change or control change during a wait |
| flag_wdata_o | output | 1 | Sticky: write data changed during a stalled write |
| flag_resp_o | output | 1 | Sticky: malformed error response |
| viol_o | output | 1 | One-cycle pulse after any failing edge |

## Verification
Each rule is judged on the rising edge that ends the cycle under test. Its result is registered once, so both viol_o and the flags show it one edge later than the cycle whose inputs broke the rule. The bench drives inputs just after a falling edge, waits for one rising edge, and samples at the next falling edge. The value it reads is therefore the verdict on exactly the cycle it just drove. Every cycle of each sweep (transfer-type pairs crossed with burst kinds, error state and control movement; write-data change points; all two-cycle response patterns) is checked this way, including the quiet cycle that follows, which confirms the pulse has dropped.

// File: rtl/ahbmon_pkg.sv
package ahbmon_pkg;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  localparam logic [2:0] BURST_UNDEF = 3'b001;

  localparam int unsigned NUM_RULES  = 3;
  localparam int unsigned RULE_CTRL  = 0;
  localparam int unsigned RULE_WDATA = 1;
  localparam int unsigned RULE_RESP  = 2;

  // Legal transfer-type step across a waited cycle
  function automatic logic step_allowed(input logic [1:0] prv,
                                        input logic [1:0] nxt,
                                        input logic [2:0] prv_burst,
                                        input logic       err_wait);
    logic ok;
    ok = 1'b0;
    if (prv == nxt)                                    ok = 1'b1;
    if (prv == TR_IDLE && nxt == TR_NSEQ)              ok = 1'b1;
    if (prv == TR_BUSY && prv_burst == BURST_UNDEF)    ok = 1'b1;
    if (prv == TR_BUSY && nxt == TR_SEQ)               ok = 1'b1;
    if (err_wait && nxt == TR_IDLE)                    ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/ahbmon_history.sv
module ahbmon_history #(
  parameter int unsigned CTRL_W = 43,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trans_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic              resp_i,
  output logic              prev_valid_o,
  output logic [1:0]        prev_trans_o,
  output logic [CTRL_W-1:0] prev_ctrl_o,
  output logic [DATA_W-1:0] prev_wdata_o,
  output logic              prev_ready_o,
  output logic              prev_resp_o,
  output logic              dphase_wr_o
);

  logic              valid_d, valid_q;
  logic [1:0]        trans_d, trans_q;
  logic [CTRL_W-1:0] ctrl_d, ctrl_q;
  logic [DATA_W-1:0] wdata_d, wdata_q;
  logic              ready_d, ready_q;
  logic              resp_d, resp_q;
  logic              dphase_d, dphase_q;
  logic              accept_en;

  always_comb begin
    accept_en = ready_i;
    valid_d   = 1'b1;
    trans_d   = trans_i;
    ctrl_d    = ctrl_i;
    wdata_d   = wdata_i;
    ready_d   = ready_i;
    resp_d    = resp_i;
    dphase_d  = dphase_q;
    if (accept_en) begin
      dphase_d = trans_i[1] & write_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      trans_q  <= '0;
      ctrl_q   <= '0;
      wdata_q  <= '0;
      ready_q  <= 1'b0;
      resp_q   <= 1'b0;
      dphase_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      trans_q  <= trans_d;
      ctrl_q   <= ctrl_d;
      wdata_q  <= wdata_d;
      ready_q  <= ready_d;
      resp_q   <= resp_d;
      dphase_q <= dphase_d;
    end
  end

  assign prev_valid_o = valid_q;
  assign prev_trans_o = trans_q;
  assign prev_ctrl_o  = ctrl_q;
  assign prev_wdata_o = wdata_q;
  assign prev_ready_o = ready_q;
  assign prev_resp_o  = resp_q;
  assign dphase_wr_o  = dphase_q;

  // R1
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_valid_o |=> prev_valid_o);

  // R2
  dphase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_i) |=> (dphase_wr_o == $past(dphase_wr_o)));

endmodule

// File: rtl/ahbmon_ctrl_rule.sv
module ahbmon_ctrl_rule
  import ahbmon_pkg::*;
#(
  parameter int unsigned CTRL_W    = 43,
  parameter int unsigned BURST_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en_i,
  input  logic              err_wait_i,
  input  logic [1:0]        trans_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [1:0]        prev_trans_i,
  input  logic [CTRL_W-1:0] prev_ctrl_i,
  output logic              fail_o
);

  logic [2:0] prev_burst;
  logic       step_ok;
  logic       type_held;
  logic       ctrl_moved;

  always_comb begin
    prev_burst = prev_ctrl_i[BURST_LSB +: 3];
    step_ok    = step_allowed(prev_trans_i, trans_i, prev_burst, err_wait_i);
    type_held  = (prev_trans_i == trans_i);
    ctrl_moved = (prev_ctrl_i != ctrl_i);
    fail_o     = chk_en_i & (~step_ok | (type_held & ctrl_moved));
  end

  // R4
  idle_to_nseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && prev_trans_i == TR_IDLE && trans_i == TR_NSEQ) |-> !fail_o);

  // R5
  fixed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && prev_trans_i == TR_BUSY && prev_burst != BURST_UNDEF &&
     trans_i != TR_SEQ && trans_i != TR_BUSY && !err_wait_i) |-> fail_o);

  // R7
  err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && err_wait_i && trans_i == TR_IDLE && prev_trans_i != TR_IDLE) |-> !fail_o);

  // R8
  ctrl_only_when_waited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> chk_en_i);

endmodule

// File: rtl/ahbmon_wdata_rule.sv
module ahbmon_wdata_rule #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en_i,
  input  logic              dphase_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] prev_wdata_i,
  output logic              fail_o
);

  logic data_moved;

  always_comb begin
    data_moved = (wdata_i != prev_wdata_i);
    fail_o     = chk_en_i & dphase_wr_i & data_moved;
  end

  // R2
  wdata_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !$stable(wdata_i));

  // R3
  read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && !dphase_wr_i) |-> !fail_o);

endmodule

// File: rtl/ahbmon_resp_rule.sv
module ahbmon_resp_rule (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_en_i,
  input  logic resp_i,
  input  logic ready_i,
  input  logic prev_resp_i,
  input  logic prev_ready_i,
  output logic fail_o
);

  logic first_half_prev;
  logic second_half_now;

  always_comb begin
    first_half_prev = prev_resp_i & ~prev_ready_i;
    second_half_now = resp_i & ready_i;
    fail_o          = chk_en_i & (first_half_prev ^ second_half_now);
  end

  // R10
  resp_involved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (resp_i || prev_resp_i));

  // R9
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_i && !prev_resp_i) |-> !fail_o);

endmodule

// File: rtl/ahb_wait_monitor.sv
module ahb_wait_monitor
  import ahbmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trans_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write_en,
  input  logic [2:0]        xfer_size,
  input  logic [2:0]        burst_kind,
  input  logic [3:0]        prot_attr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ready_in,
  input  logic              resp_err,
  output logic              flag_ctrl_o,
  output logic              flag_wdata_o,
  output logic              flag_resp_o,
  output logic              viol_o
);

  localparam int unsigned PROT_W    = 4;
  localparam int unsigned BURST_LSB = PROT_W;
  localparam int unsigned CTRL_W    = ADDR_W + 1 + 3 + 3 + PROT_W;

  logic [CTRL_W-1:0]    ctrl_now;
  logic                 prev_valid;
  logic [1:0]           prev_trans;
  logic [CTRL_W-1:0]    prev_ctrl;
  logic [DATA_W-1:0]    prev_wdata;
  logic                 prev_ready;
  logic                 prev_resp;
  logic                 dphase_wr;
  logic                 wait_chk_en;
  logic [NUM_RULES-1:0] fail_vec;
  logic [NUM_RULES-1:0] flag_d, flag_q;
  logic                 pulse_d, pulse_q;

  assign ctrl_now    = {addr, write_en, xfer_size, burst_kind, prot_attr};
  assign wait_chk_en = prev_valid & ~prev_ready;

  ahbmon_history #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .trans_i      (trans_type),
    .ctrl_i       (ctrl_now),
    .write_i      (write_en),
    .wdata_i      (wr_data),
    .ready_i      (ready_in),
    .resp_i       (resp_err),
    .prev_valid_o (prev_valid),
    .prev_trans_o (prev_trans),
    .prev_ctrl_o  (prev_ctrl),
    .prev_wdata_o (prev_wdata),
    .prev_ready_o (prev_ready),
    .prev_resp_o  (prev_resp),
    .dphase_wr_o  (dphase_wr)
  );

  ahbmon_ctrl_rule #(.CTRL_W(CTRL_W), .BURST_LSB(BURST_LSB)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en_i     (wait_chk_en),
    .err_wait_i   (prev_resp),
    .trans_i      (trans_type),
    .ctrl_i       (ctrl_now),
    .prev_trans_i (prev_trans),
    .prev_ctrl_i  (prev_ctrl),
    .fail_o       (fail_vec[RULE_CTRL])
  );

  ahbmon_wdata_rule #(.DATA_W(DATA_W)) u_wdata (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en_i     (wait_chk_en),
    .dphase_wr_i  (dphase_wr),
    .wdata_i      (wr_data),
    .prev_wdata_i (prev_wdata),
    .fail_o       (fail_vec[RULE_WDATA])
  );

  ahbmon_resp_rule u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en_i     (prev_valid),
    .resp_i       (resp_err),
    .ready_i      (ready_in),
    .prev_resp_i  (prev_resp),
    .prev_ready_i (prev_ready),
    .fail_o       (fail_vec[RULE_RESP])
  );

  genvar g;
  generate
    for (g = 0; g < NUM_RULES; g++) begin : g_flag
      always_comb begin
        flag_d[g] = flag_q[g] | fail_vec[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[g] <= 1'b0;
        else        flag_q[g] <= flag_d[g];
      end

      // R11
      sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[g] |=> flag_q[g]);
    end
  endgenerate

  always_comb begin
    pulse_d = |fail_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign flag_ctrl_o  = flag_q[RULE_CTRL];
  assign flag_wdata_o = flag_q[RULE_WDATA];
  assign flag_resp_o  = flag_q[RULE_RESP];
  assign viol_o       = pulse_q;

  // R11
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (|flag_q));

  // R1
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_valid |=> !viol_o);

endmodule

// File: tb/test_ahb_wait_monitor.sv
`timescale 1ns/1ps
module test_ahb_wait_monitor;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    trans_type;
  logic [AW-1:0] addr;
  logic          write_en;
  logic [2:0]    xfer_size;
  logic [2:0]    burst_kind;
  logic [3:0]    prot_attr;
  logic [DW-1:0] wr_data;
  logic          ready_in;
  logic          resp_err;
  logic          flag_ctrl_o, flag_wdata_o, flag_resp_o, viol_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ahb_wait_monitor #(.ADDR_W(AW), .DATA_W(DW)) i_ahb_wait_monitor (
    .clk(clk), .rst_n(rst_n), .trans_type(trans_type), .addr(addr),
    .write_en(write_en), .xfer_size(xfer_size), .burst_kind(burst_kind),
    .prot_attr(prot_attr), .wr_data(wr_data), .ready_in(ready_in),
    .resp_err(resp_err), .flag_ctrl_o(flag_ctrl_o), .flag_wdata_o(flag_wdata_o),
    .flag_resp_o(flag_resp_o), .viol_o(viol_o)
  );

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic put(logic [1:0] tr, logic [AW-1:0] ad, logic wr, logic [2:0] bu,
                     logic [DW-1:0] wd, logic rdy, logic rsp);
    trans_type = tr; addr = ad; write_en = wr; burst_kind = bu;
    wr_data = wd; ready_in = rdy; resp_err = rsp;
    xfer_size = 3'b010; prot_attr = 4'b0011;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_flags(string req, logic ec, logic ew, logic er);
    check_bit(req, "flag_ctrl", flag_ctrl_o, ec);
    check_bit(req, "flag_wdata", flag_wdata_o, ew);
    check_bit(req, "flag_resp", flag_resp_o, er);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_flags("R1", 1'b0, 1'b0, 1'b0);
    check_bit("R1", "viol in reset", viol_o, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic step_legal(logic [1:0] p, logic [1:0] n, logic [2:0] b, logic e);
    if (p == n) return 1'b1;
    if (p == T_IDLE && n == T_NSEQ) return 1'b1;
    if (p == T_BUSY && b == 3'b001) return 1'b1;
    if (p == T_BUSY && n == T_SEQ) return 1'b1;
    if (e && n == T_IDLE) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string ctrl_req(logic [1:0] p, logic [1:0] n, logic [2:0] b, logic e);
    if (p == n) return "R8";
    if (p == T_IDLE && n == T_NSEQ) return "R4";
    if (p == T_BUSY && b == 3'b001) return "R6";
    if (p == T_BUSY && n == T_SEQ) return "R5";
    if (e && n == T_IDLE) return "R7";
    if (p == T_BUSY) return "R5";
    return "R8";
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic exp_any;
    logic [AW-1:0] base;
    put(T_SEQ, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b1);
    do_reset();
    // R1: first edge after release shows a lone error second half, not checked
    tick();
    check_bit("R1", "first edge no check", viol_o, 1'b0);
    put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b0);
    tick();
    check_bit("R1", "clean after release", viol_o, 1'b0);
    check_flags("R1", 1'b0, 1'b0, 1'b0);

    // Transfer-type and control sweep: R4 R5 R6 R7 R8
    do_reset();
    exp_any = 1'b0;
    base = 32'h4000_0100;
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 4; n++)
        for (int b = 0; b < 8; b++)
          for (int e = 0; e < 2; e++)
            for (int v = 0; v < 2; v++) begin
              logic legal, exp_fail;
              logic [AW-1:0] addr_b;
              string rq;
              put(T_IDLE, base, 1'b0, 3'(b), 32'h0, 1'b1, 1'b0);
              tick();
              check_bit("R11", "quiet lead cycle", viol_o, 1'b0);
              put(2'(p), base, 1'b0, 3'(b), 32'h0, 1'b0, 1'(e));
              tick();
              check_bit("R9", "wait cycle", viol_o, 1'b0);
              addr_b = (n != p || v == 1) ? (base ^ 32'h10) : base;
              put(2'(n), addr_b, 1'b0, 3'(b), 32'h0, 1'b1, 1'(e));
              tick();
              legal = step_legal(2'(p), 2'(n), 3'(b), 1'(e));
              exp_fail = !legal || (n == p && v == 1);
              rq = ctrl_req(2'(p), 2'(n), 3'(b), 1'(e));
              exp_any |= exp_fail;
              check_bit(rq, $sformatf("type %0d->%0d burst %0d err %0d mv %0d", p, n, b, e, v),
                        viol_o, exp_fail);
              put(T_IDLE, base, 1'b0, 3'(b), 32'h0, 1'b1, 1'b0);
              tick();
              check_bit("R11", "pulse lasts one cycle", viol_o, 1'b0);
            end
    check_flags("R11", exp_any, 1'b0, 1'b0);

    // Write data stability: R2 R3
    do_reset();
    exp_any = 1'b0;
    for (int wr = 0; wr < 2; wr++)
      for (int k = 0; k < 5; k++) begin
        put(T_NSEQ, 32'h2000, 1'(wr), 3'b000, 32'hA5A5_0000, 1'b1, 1'b0);
        tick();
        for (int j = 1; j <= 4; j++) begin
          logic exp_fail;
          logic [DW-1:0] d;
          d = (k != 0 && j >= k) ? 32'h5A5A_FFFF : 32'hA5A5_0000;
          put(T_IDLE, 32'h2000, 1'(wr), 3'b000, d, (j == 4), 1'b0);
          tick();
          exp_fail = (wr == 1) && (k >= 2) && (j == k);
          exp_any |= exp_fail;
          check_bit(wr ? "R2" : "R3", $sformatf("wr %0d change at %0d cycle %0d", wr, k, j),
                    viol_o, exp_fail);
        end
        put(T_IDLE, 32'h2000, 1'(wr), 3'b000, 32'hA5A5_0000, 1'b1, 1'b0);
        tick();
        check_bit("R11", "wdata pulse drop", viol_o, 1'b0);
      end
    check_flags("R11", 1'b0, exp_any, 1'b0);

    // Response change in a wait is tolerated: R9
    do_reset();
    put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b0); tick();
    put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b0, 1'b0); tick();
    check_bit("R9", "okay wait", viol_o, 1'b0);
    put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b0, 1'b1); tick();
    check_bit("R9", "resp rises in wait", viol_o, 1'b0);
    put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b1); tick();
    check_bit("R9", "error completes", viol_o, 1'b0);
    put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b0); tick();
    check_flags("R9", 1'b0, 1'b0, 1'b0);

    // Error response shape sweep: R10
    do_reset();
    exp_any = 1'b0;
    for (int c = 0; c < 16; c++) begin
      logic r1, y1, r2, y2, f1, f2, f3;
      r1 = c[3]; y1 = c[2]; r2 = c[1]; y2 = c[0];
      put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b0); tick();
      check_bit("R10", "lead", viol_o, 1'b0);
      put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, y1, r1); tick();
      f1 = r1 & y1;
      check_bit("R10", $sformatf("pattern %0d c1", c), viol_o, f1);
      put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, y2, r2); tick();
      f2 = (r1 & ~y1) ^ (r2 & y2);
      check_bit("R10", $sformatf("pattern %0d c2", c), viol_o, f2);
      put(T_IDLE, 32'h0, 1'b0, 3'b000, 32'h0, 1'b1, 1'b0); tick();
      f3 = r2 & ~y2;
      check_bit("R10", $sformatf("pattern %0d c3", c), viol_o, f3);
      exp_any |= f1 | f2 | f3;
    end
    check_flags("R11", 1'b0, 1'b0, exp_any);

    do_reset();
    tick();
    check_flags("R1", 1'b0, 1'b0, 1'b0);

    done = 1;
    report();
  end

endmodule